// File: doc/BRIEF.md
# Serial Flash Clock and Chip-Select Timing Unit

This block produces the serial clock and the chip-select lines for a serial flash master. It does not move data. A configuration word sets the enable, the clock idle level, the sampling phase, a clock divisor, a chip-select field and a decoder-mode flag. The configuration word also reports an idle flag. A delay word holds four 8-bit counts, in reference clocks. They set the chip-select setup time, the hold time, the minimum time chip select stays high between frames, and an extra wait when the selected device changes.

A one-cycle transfer request carrying a bit count starts a frame. The block then takes these steps in order: an optional device-switch wait, chip-select setup, a burst of serial clocks, hold, and the inter-frame gap. It pulses a done strobe in the last cycle that chip select is low. It also gives sample and shift strobes that line up with the serial clock edges, so the data shifter next to it can follow the clock phase.

Top module: `spi_timing_unit`

## Requirements
- R1: After synchronous reset the chip-select lines are 4'b1111 and the serial clock is 0. The configuration word reads 32'h8000_3800: idle set, chip-select field 4'b1110 in bits [13:10], all else 0. The delay word reads 0.
- R2: Configuration bits are: enable 0, clock idle level 1, phase 2, decoder mode 9, chip-select field [13:10], divisor [22:19], idle flag 31. Delay bytes are: setup [7:0], hold [15:8], device switch [23:16], inter-frame gap [31:24]. While enable reads 1, a configuration write changes only the enable bit, and a delay write is ignored.
- R3: While enable is 0, chip select is 4'b1111, the serial clock equals the idle-level bit, and requests are ignored. Clearing enable during a frame gives both of these at once.
- R4: Every serial clock half period lasts divisor+1 reference clocks. A frame of N bits has 2N clock transitions and ends at the idle level.
- R5: While chip select is active, the lines carry the chip-select field unchanged. This holds both in one-hot active-low mode (device 0 = 1110 ... device 3 = 0111) and in decoder mode (binary code). Code 4'b1111 means no device.
- R6: The first serial clock transition comes setup+1+(divisor+1) cycles after the first cycle with chip select active.
- R7: Chip select goes inactive hold+1 cycles after the last clock transition.
- R8: The idle flag returns gap+1 cycles after chip select goes inactive. A request in that idle cycle is accepted.
- R9: The first cycle with chip select active is the cycle after the request. If the chip-select field differs from the field of the previous frame, this is delayed by exactly the device-switch count. The first frame after reset has no such delay.
- R10: Each frame gives N sample strobes and N shift strobes, each in the cycle its clock transition becomes visible. With phase 0, samples come on odd transitions (1st, 3rd, ...). With phase 1, samples come on even transitions.
- R11: The done strobe is high for exactly one cycle per frame, in the last cycle chip select is active.
- R12: The idle flag is 0 from the cycle after an accepted request until the inter-frame gap ends.
- R13: A request with zero length, or a request made while a frame is in progress, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 32 | Configuration word write value |
| cfg_rdata | output | 32 | Configuration word with idle flag |
| dly_we | input | 1 | Delay word write strobe |
| dly_wdata | input | 32 | Delay word write value |
| dly_rdata | output | 32 | Delay word read value |
| xfer_req | input | 1 | Start-of-frame request, one cycle |
| xfer_len | input | LEN_W | Number of bits in the frame |
| xfer_done | output | 1 | End-of-frame strobe |
| sclk | output | 1 | Serial clock |
| sample_stb | output | 1 | Capture strobe for incoming data |
| shift_stb | output | 1 | Launch strobe for outgoing data |
| cs_n | output | 4 | Chip-select lines or decoder code |

## Verification
The bench walks frames through several divisors, both clock levels, both phases and both chip-select modes. It measures every interval in cycles, so a delay counter off by one or a half period of divisor cycles instead of divisor+1 shows up as a wrong interval. Device changes are mixed with a repeated device and a zero switch count. A design that compares against the wrong field, or that waits even when the count is zero, asserts chip select late. Directed cases cover writes while enabled, requests during a frame, zero length and disabling mid-burst. A design that got these wrong would change its divisor, start an extra frame, or leave a clock level stuck.

// File: rtl/spt_pkg.sv
// Shared widths, field positions and types for the serial clock timing unit.
// Assumes a 32-bit register word; field positions are fixed by software.
package spt_pkg;
    localparam int REG_W  = 32;
    localparam int CS_W   = 4;
    localparam int BAUD_W = 4;
    localparam int DLY_W  = 8;

    localparam int BIT_EN    = 0;
    localparam int BIT_CPOL  = 1;
    localparam int BIT_CPHA  = 2;
    localparam int BIT_DEC   = 9;
    localparam int CS_LSB    = 10;
    localparam int BAUD_LSB  = 19;
    localparam int BIT_IDLE  = 31;

    localparam int SETUP_LSB  = 0;
    localparam int HOLD_LSB   = 8;
    localparam int SWITCH_LSB = 16;
    localparam int GAP_LSB    = 24;

    localparam logic [CS_W-1:0] CS_RESET = {{(CS_W-1){1'b1}}, 1'b0};

    typedef struct packed {
        logic [DLY_W-1:0] gap;
        logic [DLY_W-1:0] sw;
        logic [DLY_W-1:0] hold;
        logic [DLY_W-1:0] setup;
    } dly_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SWITCH, ST_SETUP, ST_BURST, ST_HOLD, ST_GAP
    } frame_st_t;
endpackage

// File: rtl/spt_cfg_regs.sv
// Configuration and delay word storage.
// Assumes writes are single-cycle strobes; while enabled only the enable bit
// of the configuration word may change and the delay word is frozen.
module spt_cfg_regs
    import spt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic              dly_we,
    input  logic [REG_W-1:0]  dly_wdata,
    input  logic              idle,
    output logic              en,
    output logic              cpol,
    output logic              cpha,
    output logic [CS_W-1:0]   cs_field,
    output logic [BAUD_W-1:0] baud,
    output dly_t              dly,
    output logic [REG_W-1:0]  cfg_rdata,
    output logic [REG_W-1:0]  dly_rdata
);
    logic decode;
    logic unused_wbits;

    assign unused_wbits = ^cfg_wdata;

    // Configuration word update, locked except for enable while running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en       <= 1'b0;
            cpol     <= 1'b0;
            cpha     <= 1'b0;
            decode   <= 1'b0;
            cs_field <= CS_RESET;
            baud     <= '0;
        end else if (cfg_we) begin
            en <= cfg_wdata[BIT_EN];
            if (!en) begin
                cpol     <= cfg_wdata[BIT_CPOL];
                cpha     <= cfg_wdata[BIT_CPHA];
                decode   <= cfg_wdata[BIT_DEC];
                cs_field <= cfg_wdata[CS_LSB +: CS_W];
                baud     <= cfg_wdata[BAUD_LSB +: BAUD_W];
            end
        end
    end

    // Delay word update, accepted only while disabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly <= '0;
        end else if (dly_we && !en) begin
            dly.setup <= dly_wdata[SETUP_LSB  +: DLY_W];
            dly.hold  <= dly_wdata[HOLD_LSB   +: DLY_W];
            dly.sw    <= dly_wdata[SWITCH_LSB +: DLY_W];
            dly.gap   <= dly_wdata[GAP_LSB    +: DLY_W];
        end
    end

    // Read-back assembly of both words
    always_comb begin
        cfg_rdata                       = '0;
        cfg_rdata[BIT_EN]               = en;
        cfg_rdata[BIT_CPOL]             = cpol;
        cfg_rdata[BIT_CPHA]             = cpha;
        cfg_rdata[BIT_DEC]              = decode;
        cfg_rdata[CS_LSB +: CS_W]       = cs_field;
        cfg_rdata[BAUD_LSB +: BAUD_W]   = baud;
        cfg_rdata[BIT_IDLE]             = idle;
        dly_rdata                       = '0;
        dly_rdata[SETUP_LSB  +: DLY_W]  = dly.setup;
        dly_rdata[HOLD_LSB   +: DLY_W]  = dly.hold;
        dly_rdata[SWITCH_LSB +: DLY_W]  = dly.sw;
        dly_rdata[GAP_LSB    +: DLY_W]  = dly.gap;
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && en) |-> ($stable(baud) && $stable(cs_field) && $stable(cpol) && $stable(cpha) && $stable(decode))); // R2
    AST_DLY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && en) |-> $stable(dly)); // R2
endmodule

// File: rtl/spt_frame_fsm.sv
// Frame sequencer: switch wait, setup, clock burst, hold and inter-frame gap.
// Assumes each delay count N stretches its phase by N cycles; the switch
// phase is skipped entirely when its count is zero.
module spt_frame_fsm
    import spt_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             req,
    input  logic [LEN_W-1:0] req_len,
    input  logic [CS_W-1:0]  cs_field,
    input  dly_t             dly,
    input  logic             burst_done,
    output logic [LEN_W-1:0] len_q,
    output logic             run,
    output logic             cs_active,
    output logic             done,
    output logic             idle
);
    frame_st_t        state;
    logic [DLY_W-1:0] cnt;
    logic [CS_W-1:0]  last_dev;
    logic             dev_seen;
    logic             cnt_zero;

    assign cnt_zero = (cnt == '0);

    // Phase sequencing; a cleared enable returns to idle at once
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            len_q    <= '0;
            last_dev <= '0;
            dev_seen <= 1'b0;
        end else if (!en) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (req && req_len != '0) begin
                    len_q    <= req_len;
                    last_dev <= cs_field;
                    dev_seen <= 1'b1;
                    if (dev_seen && cs_field != last_dev && dly.sw != '0) begin
                        state <= ST_SWITCH;
                        cnt   <= dly.sw - 1'b1;
                    end else begin
                        state <= ST_SETUP;
                        cnt   <= dly.setup;
                    end
                end
                ST_SWITCH: if (cnt_zero) begin
                    state <= ST_SETUP;
                    cnt   <= dly.setup;
                end else cnt <= cnt - 1'b1;
                ST_SETUP: if (cnt_zero) state <= ST_BURST;
                          else cnt <= cnt - 1'b1;
                ST_BURST: if (burst_done) begin
                    state <= ST_HOLD;
                    cnt   <= dly.hold;
                end
                ST_HOLD: if (cnt_zero) begin
                    state <= ST_GAP;
                    cnt   <= dly.gap;
                end else cnt <= cnt - 1'b1;
                ST_GAP: if (cnt_zero) state <= ST_IDLE;
                        else cnt <= cnt - 1'b1;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Phase decode for the clock generator and chip-select driver
    always_comb begin
        run       = en && (state == ST_BURST);
        cs_active = en && (state == ST_SETUP || state == ST_BURST || state == ST_HOLD);
        done      = en && (state == ST_HOLD) && cnt_zero;
        idle      = (state == ST_IDLE);
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_IDLE_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !cs_active); // R12
    AST_ZERO_LEN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && req && req_len == '0) |=> idle); // R13
endmodule

// File: rtl/spt_sclk_gen.sv
// Serial clock divider and edge strobes for one clock burst.
// Assumes run stays high for the whole burst; each half period lasts baud+1
// cycles and the burst ends after twice the latched length in edges.
module spt_sclk_gen
    import spt_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              cpol,
    input  logic              cpha,
    input  logic [BAUD_W-1:0] baud,
    input  logic [LEN_W-1:0]  len,
    output logic              sclk,
    output logic              sample_stb,
    output logic              shift_stb,
    output logic              burst_done
);
    localparam int ECNT_W = LEN_W + 1;

    logic [BAUD_W-1:0] hc;
    logic [ECNT_W-1:0] ecnt;
    logic [ECNT_W-1:0] last_edge;
    logic              sclk_q;
    logic              edge_q;
    logic              lead_q;
    logic              tick_edge;

    // Edge timing and end-of-burst detection
    always_comb begin
        tick_edge  = run && (hc == baud);
        last_edge  = {len, 1'b0} - 1'b1;
        burst_done = tick_edge && (ecnt == last_edge);
    end

    // Half-period counter, edge counter and clock register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hc     <= '0;
            ecnt   <= '0;
            sclk_q <= 1'b0;
            edge_q <= 1'b0;
            lead_q <= 1'b0;
        end else if (!run) begin
            hc     <= '0;
            ecnt   <= '0;
            sclk_q <= cpol;
            edge_q <= 1'b0;
            lead_q <= 1'b0;
        end else begin
            edge_q <= tick_edge;
            lead_q <= ~ecnt[0];
            if (tick_edge) begin
                hc     <= '0;
                sclk_q <= ~sclk_q;
                ecnt   <= ecnt + 1'b1;
            end else begin
                hc <= hc + 1'b1;
            end
        end
    end

    // Output clock and phase-dependent strobes
    always_comb begin
        sclk       = run ? sclk_q : cpol;
        sample_stb = edge_q & (lead_q ^ cpha);
        shift_stb  = edge_q & ~(lead_q ^ cpha);
    end

    AST_BURST_ENDS_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |=> (sclk_q == $past(cpol))); // R4
    AST_STROBE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb || shift_stb) |-> $past(run)); // R10
endmodule

// File: rtl/spi_timing_unit.sv
// Top level: serial clock and chip-select timing for a serial flash master.
// Assumes a single reference clock; data shifting is done by a neighbour
// that follows sample_stb and shift_stb.
module spi_timing_unit #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    input  logic             dly_we,
    input  logic [31:0]      dly_wdata,
    output logic [31:0]      dly_rdata,
    input  logic             xfer_req,
    input  logic [LEN_W-1:0] xfer_len,
    output logic             xfer_done,
    output logic             sclk,
    output logic             sample_stb,
    output logic             shift_stb,
    output logic [3:0]       cs_n
);
    import spt_pkg::*;

    logic              en;
    logic              cpol;
    logic              cpha;
    logic [CS_W-1:0]   cs_field;
    logic [BAUD_W-1:0] baud;
    dly_t              dly;
    logic              idle;
    logic              run;
    logic              cs_active;
    logic              burst_done;
    logic [LEN_W-1:0]  len_q;

    spt_cfg_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .dly_we    (dly_we),
        .dly_wdata (dly_wdata),
        .idle      (idle),
        .en        (en),
        .cpol      (cpol),
        .cpha      (cpha),
        .cs_field  (cs_field),
        .baud      (baud),
        .dly       (dly),
        .cfg_rdata (cfg_rdata),
        .dly_rdata (dly_rdata)
    );

    spt_frame_fsm #(.LEN_W(LEN_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .req        (xfer_req),
        .req_len    (xfer_len),
        .cs_field   (cs_field),
        .dly        (dly),
        .burst_done (burst_done),
        .len_q      (len_q),
        .run        (run),
        .cs_active  (cs_active),
        .done       (xfer_done),
        .idle       (idle)
    );

    spt_sclk_gen #(.LEN_W(LEN_W)) u_sclk (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .cpol       (cpol),
        .cpha       (cpha),
        .baud       (baud),
        .len        (len_q),
        .sclk       (sclk),
        .sample_stb (sample_stb),
        .shift_stb  (shift_stb),
        .burst_done (burst_done)
    );

    // Chip-select lines: field while a frame owns the bus, else no device
    always_comb cs_n = cs_active ? cs_field : '1;

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (cs_n == 4'hF && sclk == cpol)); // R3
    AST_IDLE_CLOCK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (sclk == cpol)); // R4
endmodule

// File: tb/spi_timing_unit_tb.sv
module spi_timing_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W = 8;
    localparam int NVEC = 6;
    // {baud, cpol, cpha, decode, cs, setup, hold, switch, gap, len}
    localparam logic [50:0] VEC [NVEC] = '{
        {4'd0,  1'b0, 1'b0, 1'b0, 4'b1110, 8'd0, 8'd0, 8'd3, 8'd0, 8'd1},
        {4'd1,  1'b1, 1'b0, 1'b0, 4'b1101, 8'd2, 8'd1, 8'd4, 8'd3, 8'd4},
        {4'd2,  1'b0, 1'b1, 1'b0, 4'b1101, 8'd5, 8'd0, 8'd7, 8'd1, 8'd3},
        {4'd3,  1'b1, 1'b1, 1'b1, 4'b0010, 8'd1, 8'd4, 8'd0, 8'd2, 8'd5},
        {4'd15, 1'b0, 1'b1, 1'b1, 4'b0011, 8'd0, 8'd2, 8'd2, 8'd0, 8'd2},
        {4'd0,  1'b1, 1'b0, 1'b0, 4'b0111, 8'd3, 8'd3, 8'd1, 8'd5, 8'd8}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic dly_we = 1'b0;
    logic xfer_req = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] dly_wdata = '0;
    logic [LEN_W-1:0] xfer_len = '0;
    logic [31:0] cfg_rdata;
    logic [31:0] dly_rdata;
    logic xfer_done, sclk, sample_stb, shift_stb;
    logic [3:0] cs_n;

    int n_checks = 0;
    int n_fail = 0;
    int m_cs_lo, m_first_edge, m_last_edge, m_cs_hi, m_idle, m_edges;
    int m_samples, m_shifts, m_first_sample, m_done_t, m_done_cnt;
    int m_cs_val, m_spacing_bad, m_idle_at1, m_end_sclk;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_timing_unit #(.LEN_W(LEN_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .dly_we(dly_we), .dly_wdata(dly_wdata), .dly_rdata(dly_rdata),
        .xfer_req(xfer_req), .xfer_len(xfer_len), .xfer_done(xfer_done),
        .sclk(sclk), .sample_stb(sample_stb), .shift_stb(shift_stb), .cs_n(cs_n)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] cfg_word(input logic en, input logic cpol, input logic cpha,
                                             input logic dec, input logic [3:0] cs, input logic [3:0] baud);
        logic [31:0] w;
        w = '0;
        w[0] = en; w[1] = cpol; w[2] = cpha; w[9] = dec;
        w[13:10] = cs; w[22:19] = baud;
        return w;
    endfunction

    task automatic wr_cfg(input logic [31:0] w);
        cfg_wdata = w; cfg_we = 1'b1; tick(); cfg_we = 1'b0;
    endtask

    task automatic wr_dly(input logic [31:0] w);
        dly_wdata = w; dly_we = 1'b1; tick(); dly_we = 1'b0;
    endtask

    task automatic pulse_req(input int len);
        xfer_req = 1'b1; xfer_len = LEN_W'(len); tick(); xfer_req = 1'b0;
    endtask

    // Issue a request and time every event of the frame in sample cycles
    task automatic run_frame(input int len, input logic cpol, input int h);
        logic prev_sclk;
        logic seen_lo;
        m_cs_lo = -1; m_first_edge = -1; m_last_edge = -1; m_cs_hi = -1; m_idle = -1;
        m_edges = 0; m_samples = 0; m_shifts = 0; m_first_sample = -1; m_done_t = -1;
        m_done_cnt = 0; m_cs_val = -1; m_spacing_bad = 0; m_idle_at1 = -1; m_end_sclk = -1;
        prev_sclk = cpol;
        seen_lo = 1'b0;
        pulse_req(len);
        for (int i = 1; i < 20000; i++) begin
            if (i == 1) m_idle_at1 = cfg_rdata[31];
            if (cs_n != 4'hF && !seen_lo) begin seen_lo = 1'b1; m_cs_lo = i; m_cs_val = cs_n; end
            if (seen_lo && cs_n == 4'hF && m_cs_hi < 0) m_cs_hi = i;
            if (sclk != prev_sclk) begin
                if (m_last_edge >= 0 && (i - m_last_edge) != h) m_spacing_bad++;
                if (m_first_edge < 0) m_first_edge = i;
                m_last_edge = i;
                m_edges++;
            end
            prev_sclk = sclk;
            if (sample_stb) begin m_samples++; if (m_first_sample < 0) m_first_sample = i; end
            if (shift_stb) m_shifts++;
            if (xfer_done) begin m_done_cnt++; m_done_t = i; end
            if (cfg_rdata[31]) begin m_idle = i; m_end_sclk = sclk; break; end
            tick();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [3:0] prev_cs;
        logic prev_valid;
        int bad;
        prev_valid = 1'b0;
        prev_cs = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        chk("R1 cs_n after reset", cs_n, 15);
        chk("R1 sclk after reset", sclk, 0);
        chk("R1 cfg word after reset", (cfg_rdata == 32'h8000_3800), 1);
        chk("R1 delay word after reset", dly_rdata, 0);

        // R3 disabled: clock follows idle level, requests ignored
        wr_cfg(cfg_word(1'b0, 1'b1, 1'b0, 1'b0, 4'b1110, 4'd0));
        chk("R3 sclk at idle level while disabled", sclk, 1);
        pulse_req(3);
        bad = 0;
        for (int k = 0; k < 6; k++) begin
            if (cs_n != 4'hF || !cfg_rdata[31] || sclk != 1'b1) bad++;
            tick();
        end
        chk("R3 request ignored while disabled", bad, 0);

        // Table of frames
        for (int v = 0; v < NVEC; v++) begin
            logic [50:0] e;
            logic [3:0] baud, cs;
            logic cpol, cpha, dec;
            int slch, chsh, d2d, shsl, len, h, e_lo, e_fe, e_le, e_hi;
            logic sw;
            logic [31:0] w;
            e = VEC[v];
            baud = e[50:47]; cpol = e[46]; cpha = e[45]; dec = e[44]; cs = e[43:40];
            slch = e[39:32]; chsh = e[31:24]; d2d = e[23:16]; shsl = e[15:8]; len = e[7:0];
            h = baud + 1;
            wr_cfg(32'h0);
            wr_cfg(cfg_word(1'b0, cpol, cpha, dec, cs, baud));
            wr_dly({8'(shsl), 8'(d2d), 8'(chsh), 8'(slch)});
            w = cfg_word(1'b1, cpol, cpha, dec, cs, baud);
            wr_cfg(w);
            chk($sformatf("R2 v%0d cfg readback", v), int'(cfg_rdata[22:0]), int'(w[22:0]));
            sw = prev_valid && (cs != prev_cs) && (d2d != 0);
            run_frame(len, cpol, h);
            e_lo = 1 + (sw ? d2d : 0);
            e_fe = e_lo + slch + 1 + h;
            e_le = e_fe + (2 * len - 1) * h;
            e_hi = e_le + chsh + 1;
            chk($sformatf("R12 v%0d idle low after request", v), m_idle_at1, 0);
            chk($sformatf("R9 v%0d cs assert cycle", v), m_cs_lo, e_lo);
            chk($sformatf("R5 v%0d cs value", v), m_cs_val, int'(cs));
            chk($sformatf("R6 v%0d setup to first edge", v), m_first_edge - m_cs_lo, slch + 1 + h);
            chk($sformatf("R4 v%0d edge count", v), m_edges, 2 * len);
            chk($sformatf("R4 v%0d edge spacing errors", v), m_spacing_bad, 0);
            chk($sformatf("R4 v%0d clock level at end", v), m_end_sclk, int'(cpol));
            chk($sformatf("R7 v%0d last edge to release", v), m_cs_hi - m_last_edge, chsh + 1);
            chk($sformatf("R8 v%0d release to idle", v), m_idle - m_cs_hi, shsl + 1);
            chk($sformatf("R10 v%0d sample count", v), m_samples, len);
            chk($sformatf("R10 v%0d shift count", v), m_shifts, len);
            chk($sformatf("R10 v%0d first sample", v), m_first_sample, e_fe + (cpha ? h : 0));
            chk($sformatf("R11 v%0d done count", v), m_done_cnt, 1);
            chk($sformatf("R11 v%0d done cycle", v), m_done_t, m_cs_hi - 1);
            prev_valid = 1'b1;
            prev_cs = cs;
        end

        // R2 lock while enabled (last row: baud 0, cs 0111, cpol 1)
        wr_cfg(cfg_word(1'b1, 1'b0, 1'b0, 1'b0, 4'b1011, 4'd9));
        chk("R2 divisor locked while enabled", int'(cfg_rdata[22:19]), 0);
        chk("R2 cs field locked while enabled", int'(cfg_rdata[13:10]), 7);
        chk("R2 idle level locked while enabled", int'(cfg_rdata[1]), 1);
        wr_dly(32'hFFFF_FFFF);
        chk("R2 delay word locked while enabled", (dly_rdata == 32'h0501_0303), 1);

        // R13 request during a frame is ignored
        pulse_req(8);
        repeat (3) tick();
        pulse_req(5);
        for (int k = 0; k < 2000 && !cfg_rdata[31]; k++) tick();
        bad = 0;
        for (int k = 0; k < 30; k++) begin
            if (cs_n != 4'hF || !cfg_rdata[31]) bad++;
            tick();
        end
        chk("R13 busy request starts no frame", bad, 0);

        // R13 zero length is ignored
        pulse_req(0);
        bad = 0;
        for (int k = 0; k < 6; k++) begin
            if (cs_n != 4'hF || !cfg_rdata[31]) bad++;
            tick();
        end
        chk("R13 zero length ignored", bad, 0);

        // R3 disable in the middle of a burst
        pulse_req(8);
        repeat (6) tick();
        wr_cfg(32'h0);
        chk("R3 cs released on disable", cs_n, 15);
        chk("R3 sclk at idle level on disable", sclk, 1);
        tick();
        chk("R3 idle after disable", int'(cfg_rdata[31]), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule